// File: doc/BRIEF.md
# FIFO Trigger Level and Occupancy Register Block

This block is the register-side front end for the threshold logic of a serial port whose transmit and receive queues each hold up to 128 characters. It keeps a byte of feature control. In that byte, one bit picks the transmit or receive side, one bit changes the meaning of the scratch location, and a two-bit field picks one of four preset threshold tables. The same control byte also chooses which side a shared trigger address acts on. A write to the trigger address loads a custom threshold for the chosen side. A read of that address returns that side's live character count.

The block drives the active threshold for each side and two comparison flags. The receive flag means enough data is waiting. The transmit flag means the transmit queue has drained down to its threshold. The occupancy counts come from the queues, which are outside this block. Register reads are combinational from the current address. Writes take effect at the clock edge.

Top module: `fifo_trig_regs`

## Requirements
- R1: While reset is active and after it is released, the control byte reads 0x00, the receive threshold is 8, the transmit threshold is 16, the scratch byte is 0x00, the enhanced-mode byte is 0x00 and no custom threshold is active.
- R2: Control bits 5:4 select the preset thresholds for both sides: 0 gives rx 8 / tx 16, 1 gives rx 16 / tx 8, 2 gives rx 56 / tx 32, and 3 gives rx 120 / tx 64.
- R3: A write to the trigger address (offset 0) sets the receive threshold to the written byte when control bit 7 is 0, or sets the transmit threshold when bit 7 is 1. The threshold of the other side is unchanged.
- R4: A custom threshold persists across control writes that leave bits 5:4 unchanged. A control write that changes bits 5:4 drops both custom thresholds, and both sides return to the newly selected preset.
- R5: A read of the trigger address returns the receive count when control bit 7 is 0 and the transmit count when it is 1, for any count from 0 to 128.
- R6: When control bit 6 is 0, the scratch address (offset 7) is a plain read/write byte, and writing it leaves the enhanced-mode byte unchanged.
- R7: When control bit 6 is 1, a read of the scratch address returns the count of the side chosen by bit 7. A write there loads the enhanced-mode byte and leaves the stored scratch byte intact.
- R8: rx_hit is 1 exactly when rx_count is greater than or equal to the receive threshold.
- R9: tx_hit is 1 exactly when tx_count is less than or equal to the transmit threshold.
- R10: The control address (offset 2) reads back the last byte written to it, and every unmapped address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register at reg_addr |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_count | input | 8 | Receive queue occupancy, 0 to 128 |
| tx_count | input | 8 | Transmit queue occupancy, 0 to 128 |
| rx_level | output | 8 | Active receive threshold |
| tx_level | output | 8 | Active transmit threshold |
| rx_hit | output | 1 | Receive occupancy has reached its threshold |
| tx_hit | output | 1 | Transmit occupancy is at or below its threshold |
| enh_mode | output | 8 | Enhanced-mode byte |

## Verification
The hardest state to reach is a custom threshold on one side that survives a later control write. Reaching it needs three writes in order: a control write with the side bit set, a trigger write, and a control write that flips the side bit but keeps the table field. Only after that can a table change show that both custom values are dropped. The vector table walks this sequence in order and checks the threshold outputs at each step.

The scratch byte's survival through enhanced mode is checked the same way. The scratch byte is written in plain mode. The block is then switched to count mode, the scratch address is written there, and the block is switched back. A final read must return the old scratch value.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  localparam int CTL_SIDE_BIT  = 7;  // 1: transmit side addressed
  localparam int CTL_CMODE_BIT = 6;  // 1: scratch address shows count
  localparam int CTL_TBL_LO    = 4;  // two-bit table field

  function automatic logic [7:0] preset_level(input logic [1:0] tbl, input logic tx_side);
    logic [7:0] lvl;
    case (tbl)
      2'd0:    lvl = tx_side ? 8'd16 : 8'd8;
      2'd1:    lvl = tx_side ? 8'd8  : 8'd16;
      2'd2:    lvl = tx_side ? 8'd32 : 8'd56;
      default: lvl = tx_side ? 8'd64 : 8'd120;
    endcase
    return lvl;
  endfunction
endpackage

// File: rtl/trg_ctl_regs.sv
module trg_ctl_regs
  import fifo_trig_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter int ADDR_CTL = 2,
  parameter int ADDR_SCR = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] scr_q,
  output logic [DW-1:0] enh_q,
  output logic          tbl_change
);
  logic ctl_en, scr_en, enh_en;

  always_comb begin
    ctl_en     = wr_en && (addr == AW'(ADDR_CTL));
    scr_en     = wr_en && (addr == AW'(ADDR_SCR)) && !ctl_q[CTL_CMODE_BIT];
    enh_en     = wr_en && (addr == AW'(ADDR_SCR)) &&  ctl_q[CTL_CMODE_BIT];
    tbl_change = ctl_en &&
                 (wdata[CTL_TBL_LO +: 2] != ctl_q[CTL_TBL_LO +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      scr_q <= '0;
      enh_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= wdata;
      if (scr_en) scr_q <= wdata;
      if (enh_en) enh_q <= wdata;
    end
  end
endmodule

// File: rtl/trg_level_side.sv
module trg_level_side
  import fifo_trig_pkg::*;
#(
  parameter int  DW      = 8,
  parameter bit  TX_SIDE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    tbl_sel,
  input  logic          load,
  input  logic          clear,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] level
);
  logic          cust_vld_q, cust_vld_d;
  logic [DW-1:0] cust_q;
  logic          cust_en;

  always_comb begin
    cust_en    = load && !clear;
    cust_vld_d = cust_vld_q;
    if (clear)     cust_vld_d = 1'b0;
    else if (load) cust_vld_d = 1'b1;
    level = cust_vld_q ? cust_q : DW'(preset_level(tbl_sel, TX_SIDE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cust_vld_q <= 1'b0;
      cust_q     <= '0;
    end else begin
      cust_vld_q <= cust_vld_d;
      if (cust_en) cust_q <= wdata;
    end
  end
endmodule

// File: rtl/trg_readback.sv
module trg_readback
  import fifo_trig_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CW       = 8,
  parameter int AW       = 3,
  parameter int ADDR_TRG = 0,
  parameter int ADDR_CTL = 2,
  parameter int ADDR_SCR = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ctl_q,
  input  logic [DW-1:0] scr_q,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic [DW-1:0] rx_level,
  input  logic [DW-1:0] tx_level,
  output logic [DW-1:0] rdata,
  output logic          rx_hit,
  output logic          tx_hit
);
  localparam int MW = (DW > CW) ? DW : CW;
  logic [DW-1:0] sel_cnt;

  always_comb begin
    sel_cnt = ctl_q[CTL_SIDE_BIT] ? DW'(tx_count) : DW'(rx_count);
    if (addr == AW'(ADDR_TRG))      rdata = sel_cnt;
    else if (addr == AW'(ADDR_CTL)) rdata = ctl_q;
    else if (addr == AW'(ADDR_SCR)) rdata = ctl_q[CTL_CMODE_BIT] ? sel_cnt : scr_q;
    else                            rdata = '0;
    rx_hit = MW'(rx_count) >= MW'(rx_level);
    tx_hit = MW'(tx_count) <= MW'(tx_level);
  end
endmodule

// File: rtl/fifo_trig_regs.sv
module fifo_trig_regs
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter int ADDR_TRG = 0,
  parameter int ADDR_CTL = 2,
  parameter int ADDR_SCR = 7,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic [DW-1:0] rx_level,
  output logic [DW-1:0] tx_level,
  output logic          rx_hit,
  output logic          tx_hit,
  output logic [DW-1:0] enh_mode
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [DW-1:0] ctl_q, scr_q;
  logic          tbl_change;
  logic [DW-1:0] side_level [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  trg_ctl_regs #(.DW(DW), .AW(AW), .ADDR_CTL(ADDR_CTL), .ADDR_SCR(ADDR_SCR)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .ctl_q(ctl_q), .scr_q(scr_q), .enh_q(enh_mode),
    .tbl_change(tbl_change)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic ld;
    assign ld = reg_wr && (reg_addr == AW'(ADDR_TRG)) &&
                (ctl_q[CTL_SIDE_BIT] == s[0]);
    trg_level_side #(.DW(DW), .TX_SIDE(s[0])) u_lvl (
      .clk(clk), .rst_n(rst_sync_n), .tbl_sel(ctl_q[CTL_TBL_LO +: 2]),
      .load(ld), .clear(tbl_change), .wdata(reg_wdata),
      .level(side_level[s])
    );
  end

  assign rx_level = side_level[0];
  assign tx_level = side_level[1];

  trg_readback #(.DW(DW), .CW(CW), .AW(AW), .ADDR_TRG(ADDR_TRG),
                 .ADDR_CTL(ADDR_CTL), .ADDR_SCR(ADDR_SCR)) u_rd (
    .addr(reg_addr), .ctl_q(ctl_q), .scr_q(scr_q), .rx_count(rx_count),
    .tx_count(tx_count), .rx_level(rx_level), .tx_level(tx_level),
    .rdata(reg_rdata), .rx_hit(rx_hit), .tx_hit(tx_hit)
  );
endmodule

// File: rtl/fifo_trig_regs_chk.sv
module fifo_trig_regs_chk
  import fifo_trig_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CW       = 8,
  parameter int AW       = 3,
  parameter int ADDR_TRG = 0,
  parameter int ADDR_CTL = 2,
  parameter int ADDR_SCR = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] ctl_q,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [DW-1:0] rx_level,
  input logic [DW-1:0] tx_level,
  input logic          rx_hit,
  input logic          tx_hit,
  input logic [DW-1:0] enh_mode
);
  localparam int MW = (DW > CW) ? DW : CW;

  // R3
  rx_custom_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADDR_TRG) && !ctl_q[CTL_SIDE_BIT])
    |=> (rx_level == $past(reg_wdata)) && $stable(tx_level));

  // R3
  tx_custom_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADDR_TRG) && ctl_q[CTL_SIDE_BIT])
    |=> (tx_level == $past(reg_wdata)) && $stable(rx_level));

  // R4
  table_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADDR_CTL) &&
     reg_wdata[CTL_TBL_LO +: 2] != ctl_q[CTL_TBL_LO +: 2])
    |=> (rx_level == DW'(preset_level(ctl_q[CTL_TBL_LO +: 2], 1'b0))) &&
        (tx_level == DW'(preset_level(ctl_q[CTL_TBL_LO +: 2], 1'b1))));

  // R6
  plain_scr_keeps_enh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADDR_SCR) && !ctl_q[CTL_CMODE_BIT])
    |=> $stable(enh_mode));

  // R7
  enh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADDR_SCR) && ctl_q[CTL_CMODE_BIT])
    |=> (enh_mode == $past(reg_wdata)));

  // R8
  rx_hit_at_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MW'(rx_count) == MW'(rx_level)) |-> rx_hit);

  // R9
  tx_hit_at_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MW'(tx_count) == MW'(tx_level)) |-> tx_hit);
endmodule

bind fifo_trig_regs fifo_trig_regs_chk #(
  .DW(DW), .CW(CW), .AW(AW),
  .ADDR_TRG(ADDR_TRG), .ADDR_CTL(ADDR_CTL), .ADDR_SCR(ADDR_SCR)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ctl_q(ctl_q), .rx_count(rx_count),
  .tx_count(tx_count), .rx_level(rx_level), .tx_level(tx_level),
  .rx_hit(rx_hit), .tx_hit(tx_hit), .enh_mode(enh_mode)
);

// File: tb/fifo_trig_regs_test.sv
`timescale 1ns/1ps
module fifo_trig_regs_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] rx_count, tx_count, rx_level, tx_level, enh_mode;
  logic       rx_hit, tx_hit;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_trig_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_count(rx_count),
    .tx_count(tx_count), .rx_level(rx_level), .tx_level(tx_level),
    .rx_hit(rx_hit), .tx_hit(tx_hit), .enh_mode(enh_mode)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic       wr;
    logic [2:0] addr;
    logic [7:0] wd;
    logic [7:0] rxc;
    logic [7:0] txc;
    logic [7:0] erd;
    logic [7:0] erx;
    logic [7:0] etx;
    logic       erh;
    logic       eth;
    logic [7:0] een;
  } vec_t;

  localparam int NV = 21;
  // offsets: trigger 0, control 2, scratch 7, 1 unmapped
  localparam vec_t VEC [NV] = '{
    '{4'd5,  1'b0, 3'd0, 8'h00, 8'd5,   8'd20, 8'd5,   8'd8,   8'd16, 1'b0, 1'b0, 8'h00}, // R5 R8 R9
    '{4'd8,  1'b0, 3'd0, 8'h00, 8'd8,   8'd16, 8'd8,   8'd8,   8'd16, 1'b1, 1'b1, 8'h00}, // R8 R9 equality
    '{4'd2,  1'b1, 3'd2, 8'h10, 8'd8,   8'd16, 8'h10,  8'd16,  8'd8,  1'b0, 1'b0, 8'h00}, // R2 table 1
    '{4'd2,  1'b1, 3'd2, 8'h20, 8'd56,  8'd33, 8'h20,  8'd56,  8'd32, 1'b1, 1'b0, 8'h00}, // R2 table 2
    '{4'd2,  1'b1, 3'd2, 8'h30, 8'd128, 8'd0,  8'h30,  8'd120, 8'd64, 1'b1, 1'b1, 8'h00}, // R2 table 3
    '{4'd5,  1'b0, 3'd0, 8'h00, 8'd128, 8'd0,  8'd128, 8'd120, 8'd64, 1'b1, 1'b1, 8'h00}, // R5 full count
    '{4'd10, 1'b1, 3'd2, 8'hB0, 8'd3,   8'd64, 8'hB0,  8'd120, 8'd64, 1'b0, 1'b1, 8'h00}, // R10
    '{4'd5,  1'b0, 3'd0, 8'h00, 8'd3,   8'd64, 8'd64,  8'd120, 8'd64, 1'b0, 1'b1, 8'h00}, // R5 tx side
    '{4'd3,  1'b1, 3'd0, 8'd5,  8'd3,   8'd6,  8'd6,   8'd120, 8'd5,  1'b0, 1'b0, 8'h00}, // R3 tx custom
    '{4'd4,  1'b1, 3'd2, 8'h30, 8'd3,   8'd5,  8'h30,  8'd120, 8'd5,  1'b0, 1'b1, 8'h00}, // R4 persists
    '{4'd3,  1'b1, 3'd0, 8'd2,  8'd2,   8'd9,  8'd2,   8'd2,   8'd5,  1'b1, 1'b0, 8'h00}, // R3 rx custom
    '{4'd4,  1'b1, 3'd2, 8'h00, 8'd2,   8'd9,  8'h00,  8'd8,   8'd16, 1'b0, 1'b1, 8'h00}, // R4 cleared
    '{4'd6,  1'b1, 3'd7, 8'h5A, 8'd0,   8'd0,  8'h5A,  8'd8,   8'd16, 1'b0, 1'b1, 8'h00}, // R6
    '{4'd10, 1'b0, 3'd1, 8'h00, 8'd0,   8'd0,  8'h00,  8'd8,   8'd16, 1'b0, 1'b1, 8'h00}, // R10 unmapped
    '{4'd7,  1'b1, 3'd2, 8'h40, 8'd77,  8'd0,  8'h40,  8'd8,   8'd16, 1'b1, 1'b1, 8'h00}, // R7 enter
    '{4'd7,  1'b0, 3'd7, 8'h00, 8'd77,  8'd0,  8'd77,  8'd8,   8'd16, 1'b1, 1'b1, 8'h00}, // R7 rx count
    '{4'd7,  1'b1, 3'd7, 8'hC3, 8'd77,  8'd0,  8'd77,  8'd8,   8'd16, 1'b1, 1'b1, 8'hC3}, // R7 enh write
    '{4'd7,  1'b1, 3'd2, 8'hC0, 8'd77,  8'd99, 8'hC0,  8'd8,   8'd16, 1'b1, 1'b0, 8'hC3}, // R7 tx side
    '{4'd7,  1'b0, 3'd7, 8'h00, 8'd77,  8'd99, 8'd99,  8'd8,   8'd16, 1'b1, 1'b0, 8'hC3}, // R7 tx count
    '{4'd10, 1'b1, 3'd2, 8'h00, 8'd77,  8'd99, 8'h00,  8'd8,   8'd16, 1'b1, 1'b0, 8'hC3}, // R10
    '{4'd7,  1'b0, 3'd7, 8'h00, 8'd77,  8'd99, 8'h5A,  8'd8,   8'd16, 1'b1, 1'b0, 8'hC3}  // R7 scratch kept
  };

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=0x%02h expected=0x%02h", tag, what, act, exp);
    end
  endtask

  task automatic check_defaults(input string tag);
    vectors++;
    check8(tag, "rx_level", rx_level, 8'd8);
    check8(tag, "tx_level", tx_level, 8'd16);
    check8(tag, "enh_mode", enh_mode, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd2; reg_wdata = '0;
    rx_count = '0; tx_count = '0;
    #1;
    // R1 values during reset
    check_defaults("R1");
    vectors++;
    check8("R1", "ctl read", reg_rdata, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_defaults("R1");

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      reg_wr = VEC[i].wr; reg_addr = VEC[i].addr; reg_wdata = VEC[i].wd;
      rx_count = VEC[i].rxc; tx_count = VEC[i].txc;
      @(posedge clk); #1;
      tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      vectors++;
      check8(tag, "rdata",    reg_rdata, VEC[i].erd);
      check8(tag, "rx_level", rx_level,  VEC[i].erx);
      check8(tag, "tx_level", tx_level,  VEC[i].etx);
      check8(tag, "rx_hit",   8'(rx_hit), 8'(VEC[i].erh));
      check8(tag, "tx_hit",   8'(tx_hit), 8'(VEC[i].eth));
      check8(tag, "enh_mode", enh_mode,  VEC[i].een);
    end

    // R1 mid-run reset clears customs, scratch and enhanced byte
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'd33;
    @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 8'h05;
    @(negedge clk);
    reg_wr = 1'b0;
    rst_n = 1'b0;
    #1;
    check_defaults("R1");
    vectors++;
    check8("R1", "ctl after reset", reg_rdata, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_addr = 3'd7;
    #1;
    vectors++;
    check8("R1", "scratch after reset", reg_rdata, 8'h00);

    // R8 R9 boundaries one step away from the thresholds
    rx_count = 8'd7; tx_count = 8'd17;
    #1;
    vectors++;
    check8("R8", "rx_hit below", 8'(rx_hit), 8'd0);
    check8("R9", "tx_hit above", 8'(tx_hit), 8'd0);
    rx_count = 8'd9; tx_count = 8'd15;
    #1;
    vectors++;
    check8("R8", "rx_hit above", 8'(rx_hit), 8'd1);
    check8("R9", "tx_hit below", 8'(tx_hit), 8'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule